// File: doc/BRIEF.md
# Sampling Converter Acquisition Controller

This block sits on the host side of a successive-approximation converter. The converter is driven by only two control lines, a sample line and a conversion clock, plus a calibrate line. The controller produces all three. On each accepted start request it raises the sample line for a fixed acquisition window and then lowers it, which freezes the input. After a fixed settling delay it sends a burst of exactly seventeen conversion clocks. It then waits for the converter's busy flag to fall and latches the parallel result word with a one-cycle strobe, so a processor bus can collect it.

After reset the controller waits a programmable stabilisation time and then runs a calibration. It pulses the calibrate line, runs the conversion clock freely while the converter calibrates, and watches for busy to fall. It then adds the single extra clock the converter needs to close calibration. The busy flag is asynchronous to the system clock and passes through a synchronizer before any edge is taken from it. A conversion whose busy flag never drops is abandoned after a timeout and reported on an error line.

Top module: `acq_ctrl`

## Requirements
- R1: After reset is released, `cal_o` rises exactly STAB_CYC system cycles later and stays high for exactly CAL_HI_CYC cycles. `cal_o` and `sample_o` are never high together.
- R2: While the converter calibrates, `cclk_o` toggles every HALF cycles. After busy falls, `cclk_o` rests low and then delivers exactly one more pulse before `ready_o` rises. No result strobe is produced for a calibration.
- R3: A start accepted while `ready_o` is high drives `sample_o` high for exactly ACQ_CYC system cycles.
- R4: The first `cclk_o` rise of a conversion comes exactly CLK_DLY system cycles after `sample_o` falls. `cclk_o` stays low in between.
- R5: Each conversion issues exactly N_CLK (17) `cclk_o` pulses, each high for HALF cycles and low for HALF cycles.
- R6: `busy_i` passes through a two-stage synchronizer. Its synchronized falling edge during a conversion copies `data_i` to `data_o` and pulses `valid_o` for one cycle. `data_o` holds that word until the next capture.
- R7: `ready_o` is low from the accepted start until the conversion or calibration ends. A start request while `ready_o` is low is dropped and yields no extra acquisition.
- R8: Between two acquisitions `sample_o` stays low for at least LOW_CYC cycles. A new acquisition only starts after the previous busy flag has fallen.
- R9: If busy has not fallen TO_CYC cycles after the last clock of the burst, `err_o` goes high, the controller returns to ready and no strobe is given. `err_o` clears on the next accepted start or calibration request.
- R10: `cal_req_i` while ready repeats the calibration sequence of R2. It wins over `start_i` when both are high in the same cycle.
- R11: A busy fall while the controller is idle is ignored: no strobe, and `data_o` is unchanged.
- R12: During reset, `sample_o`, `cal_o`, `cclk_o`, `ready_o`, `valid_o`, `err_o` and `data_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Conversion request, taken when ready_o is high |
| cal_req_i | input | 1 | Calibration request, taken when ready_o is high |
| busy_i | input | 1 | Converter busy flag, asynchronous |
| data_i | input | DATA_W | Converter parallel result |
| sample_o | output | 1 | Acquisition control to the converter |
| cal_o | output | 1 | Calibrate control to the converter |
| cclk_o | output | 1 | Gated conversion clock |
| ready_o | output | 1 | Controller can accept a request |
| data_o | output | DATA_W | Captured result word |
| valid_o | output | 1 | One-cycle strobe for a new data_o |
| err_o | output | 1 | Busy timeout flag |

## Verification
The bound checker watches several rules on every cycle. It checks the acquisition width and the minimum low gap through its own run counters. It checks that the first clock edge never coincides with the sample fall, that the strobe lasts one cycle, and that the outputs stay quiet while ready. Only the bench scenarios can show the counted properties. These are the exact number of conversion clocks, the settling delay in cycles, the single closing pulse after calibration, the captured word values, and the timeout path. They depend on a converter model that answers the controller's pulses.

// File: rtl/acq_pkg.sv
package acq_pkg;
   typedef enum logic [3:0] {
      ST_PWR, ST_CAL_HI, ST_CAL_WAIT, ST_CAL_GAP, ST_CAL_XTRA,
      ST_IDLE, ST_ACQ, ST_DLY, ST_RUN, ST_WAIT
   } acq_state_e;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/acq_busy_sync.sv
module acq_busy_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic fall_o
);
   logic [STAGES-1:0] sr_q;
   logic              last_q;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sr_q[0] <= 1'b0;
               else        sr_q[0] <= async_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sr_q[gi] <= 1'b0;
               else        sr_q[gi] <= sr_q[gi-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= sr_q[STAGES-1];
   end

   assign fall_o = last_q & ~sr_q[STAGES-1];
endmodule

// File: rtl/acq_clk_burst.sv
module acq_clk_burst #(
   parameter int HALF = 2,
   parameter int NP_W = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            go_i,
   input  logic [NP_W-1:0] count_i,
   input  logic            free_run_i,
   output logic            cclk_o,
   output logic            done_o
);
   localparam int PH_W = (HALF > 1) ? $clog2(HALF) : 1;

   logic            cclk_q, act_q;
   logic [PH_W-1:0] ph_q;
   logic [NP_W-1:0] pl_q;
   logic            ph_last;

   assign ph_last = (ph_q == PH_W'(HALF-1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cclk_q <= 1'b0;
         act_q  <= 1'b0;
         ph_q   <= '0;
         pl_q   <= '0;
      end else if (go_i) begin
         act_q  <= 1'b1;
         cclk_q <= 1'b1;
         ph_q   <= '0;
         pl_q   <= NP_W'(count_i - 1'b1);
      end else if (act_q) begin
         if (ph_last) begin
            ph_q <= '0;
            if (cclk_q) begin
               cclk_q <= 1'b0;
            end else if (pl_q == '0) begin
               act_q <= 1'b0;
            end else begin
               cclk_q <= 1'b1;
               pl_q   <= pl_q - 1'b1;
            end
         end else begin
            ph_q <= ph_q + 1'b1;
         end
      end else if (free_run_i) begin
         if (ph_last) begin
            ph_q   <= '0;
            cclk_q <= ~cclk_q;
         end else begin
            ph_q <= ph_q + 1'b1;
         end
      end else begin
         cclk_q <= 1'b0;
         ph_q   <= '0;
      end
   end

   assign cclk_o = cclk_q;
   assign done_o = act_q & ~cclk_q & ph_last & (pl_q == '0);
endmodule

// File: rtl/acq_capture.sv
module acq_capture #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [DATA_W-1:0] data_o,
   output logic              valid_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_o  <= '0;
         valid_o <= 1'b0;
      end else begin
         valid_o <= en_i;
         if (en_i) data_o <= data_i;
      end
   end
endmodule

// File: rtl/acq_ctrl.sv
module acq_ctrl #(
   parameter int DATA_W     = 16,
   parameter int STAB_CYC   = 40,
   parameter int CAL_HI_CYC = 4,
   parameter int ACQ_CYC    = 6,
   parameter int LOW_CYC    = 100,
   parameter int CLK_DLY    = 3,
   parameter int N_CLK      = 17,
   parameter int HALF       = 2,
   parameter int TO_CYC     = 64,
   parameter int SYNC_N     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              cal_req_i,
   input  logic              busy_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              sample_o,
   output logic              cal_o,
   output logic              cclk_o,
   output logic              ready_o,
   output logic [DATA_W-1:0] data_o,
   output logic              valid_o,
   output logic              err_o
);
   import acq_pkg::*;

   localparam int CNT_MAX = max2(max2(STAB_CYC, TO_CYC),
                                 max2(max2(CAL_HI_CYC, ACQ_CYC), CLK_DLY));
   localparam int CNT_W   = $clog2(CNT_MAX + 1);
   localparam int NP_W    = $clog2(N_CLK + 1);
   localparam int LW      = $clog2(LOW_CYC + 1);

   generate
      if (STAB_CYC < 1 || CAL_HI_CYC < 1 || ACQ_CYC < 1 || CLK_DLY < 1 ||
          N_CLK < 1 || HALF < 1 || TO_CYC < 1 || LOW_CYC < 1) begin : g_bad_timing
         $error("acq_ctrl: every timing parameter must be at least 1");
      end
      if (SYNC_N < 2) begin : g_bad_sync
         $error("acq_ctrl: synchronizer needs two or more stages");
      end
   endgenerate

   acq_state_e        state_q, state_n;
   logic [CNT_W-1:0]  cnt_q, cnt_n;
   logic [LW-1:0]     low_q;
   logic              sample_q, cal_q, seen_q, err_q;
   logic              fall, burst_done, go;
   logic [NP_W-1:0]   go_cnt;
   logic              cap_en, err_set, err_clr, low_ok, rdy;

   acq_busy_sync #(.STAGES(SYNC_N)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_i(busy_i), .fall_o(fall)
   );

   acq_clk_burst #(.HALF(HALF), .NP_W(NP_W)) u_burst (
      .clk(clk), .rst_n(rst_n), .go_i(go), .count_i(go_cnt),
      .free_run_i(state_q == ST_CAL_WAIT), .cclk_o(cclk_o), .done_o(burst_done)
   );

   acq_capture #(.DATA_W(DATA_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .en_i(cap_en), .data_i(data_i),
      .data_o(data_o), .valid_o(valid_o)
   );

   assign low_ok = (low_q == LW'(LOW_CYC));
   assign rdy    = (state_q == ST_IDLE) && low_ok;
   assign cap_en = fall && (state_q == ST_RUN || state_q == ST_WAIT);

   always_comb begin
      state_n = state_q;
      cnt_n   = cnt_q + 1'b1;
      go      = 1'b0;
      go_cnt  = NP_W'(N_CLK);
      err_set = 1'b0;
      err_clr = 1'b0;
      unique case (state_q)
         ST_PWR: if (cnt_q == CNT_W'(STAB_CYC-1)) begin
            state_n = ST_CAL_HI; cnt_n = '0;
         end
         ST_CAL_HI: if (cnt_q == CNT_W'(CAL_HI_CYC-1)) begin
            state_n = ST_CAL_WAIT; cnt_n = '0;
         end
         ST_CAL_WAIT: begin
            cnt_n = '0;
            if (fall) state_n = ST_CAL_GAP;
         end
         ST_CAL_GAP: if (cnt_q == CNT_W'(CLK_DLY-1)) begin
            go = 1'b1; go_cnt = NP_W'(1); state_n = ST_CAL_XTRA; cnt_n = '0;
         end
         ST_CAL_XTRA: begin
            cnt_n = '0;
            if (burst_done) state_n = ST_IDLE;
         end
         ST_IDLE: begin
            cnt_n = '0;
            if (rdy && cal_req_i) begin
               state_n = ST_CAL_HI; err_clr = 1'b1;
            end else if (rdy && start_i) begin
               state_n = ST_ACQ; err_clr = 1'b1;
            end
         end
         ST_ACQ: if (cnt_q == CNT_W'(ACQ_CYC-1)) begin
            state_n = ST_DLY; cnt_n = '0;
         end
         ST_DLY: if (cnt_q == CNT_W'(CLK_DLY-1)) begin
            go = 1'b1; state_n = ST_RUN; cnt_n = '0;
         end
         ST_RUN: begin
            cnt_n = '0;
            if (burst_done) state_n = (seen_q || fall) ? ST_IDLE : ST_WAIT;
         end
         ST_WAIT: begin
            if (fall) begin
               state_n = ST_IDLE; cnt_n = '0;
            end else if (cnt_q == CNT_W'(TO_CYC-1)) begin
               err_set = 1'b1; state_n = ST_IDLE; cnt_n = '0;
            end
         end
         default: begin
            state_n = ST_IDLE; cnt_n = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_PWR;
         cnt_q    <= '0;
         sample_q <= 1'b0;
         cal_q    <= 1'b0;
         seen_q   <= 1'b0;
         err_q    <= 1'b0;
         low_q    <= LW'(LOW_CYC);
      end else begin
         state_q  <= state_n;
         cnt_q    <= cnt_n;
         sample_q <= (state_n == ST_ACQ);
         cal_q    <= (state_n == ST_CAL_HI);
         if (go && state_q == ST_DLY) seen_q <= 1'b0;
         else if (cap_en)             seen_q <= 1'b1;
         if (err_set)      err_q <= 1'b1;
         else if (err_clr) err_q <= 1'b0;
         if (sample_q)     low_q <= '0;
         else if (!low_ok) low_q <= low_q + 1'b1;
      end
   end

   assign sample_o = sample_q;
   assign cal_o    = cal_q;
   assign ready_o  = rdy;
   assign err_o    = err_q;
endmodule

// File: rtl/acq_ctrl_chk.sv
module acq_ctrl_chk #(
   parameter int ACQ_CYC = 6,
   parameter int LOW_CYC = 100
) (
   input logic clk,
   input logic rst_n,
   input logic sample_o,
   input logic cal_o,
   input logic cclk_o,
   input logic ready_o,
   input logic valid_o,
   input logic err_o
);
   logic [15:0] hi_run, lo_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_run <= '0;
         lo_run <= 16'(LOW_CYC);
      end else begin
         if (sample_o) hi_run <= (hi_run == 16'hFFFF) ? hi_run : hi_run + 1'b1;
         else          hi_run <= '0;
         if (sample_o) lo_run <= '0;
         else if (lo_run < 16'(LOW_CYC)) lo_run <= lo_run + 1'b1;
      end
   end

   // R1
   cal_sample_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cal_o && sample_o));
   // R3
   acq_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sample_o) |-> hi_run == 16'(ACQ_CYC));
   // R4
   clk_after_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sample_o) |-> !cclk_o);
   // R6
   valid_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);
   // R7
   ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o |-> (!sample_o && !cclk_o && !cal_o));
   // R8
   low_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sample_o) |-> lo_run >= 16'(LOW_CYC));
   // R9
   err_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_o) |-> !valid_o);
endmodule

bind acq_ctrl acq_ctrl_chk #(.ACQ_CYC(ACQ_CYC), .LOW_CYC(LOW_CYC)) u_chk (
   .clk(clk), .rst_n(rst_n), .sample_o(sample_o), .cal_o(cal_o),
   .cclk_o(cclk_o), .ready_o(ready_o), .valid_o(valid_o), .err_o(err_o)
);

// File: tb/tb_acq_ctrl.sv
module tb_acq_ctrl;
   localparam int DATA_W = 16, STAB_CYC = 40, CAL_HI_CYC = 4, ACQ_CYC = 6;
   localparam int LOW_CYC = 100, CLK_DLY = 3, N_CLK = 17, HALF = 2, TO_CYC = 64;
   localparam int CAL_CLKS = 12;
   localparam int NV = 6;
   // each entry: {word driven by converter model, word expected on data_o}
   localparam logic [31:0] VEC [NV] = '{
      {16'h0000, 16'h0000}, {16'hFFFF, 16'hFFFF}, {16'hA5C3, 16'hA5C3},
      {16'h0001, 16'h0001}, {16'h8000, 16'h8000}, {16'h7FFE, 16'h7FFE}};

   logic clk = 0, rst_n = 0, start_i = 0, cal_req_i = 0, busy_i = 0;
   logic [DATA_W-1:0] data_i = '0;
   logic sample_o, cal_o, cclk_o, ready_o, valid_o, err_o;
   logic [DATA_W-1:0] data_o;

   acq_ctrl #(.DATA_W(DATA_W), .STAB_CYC(STAB_CYC), .CAL_HI_CYC(CAL_HI_CYC),
      .ACQ_CYC(ACQ_CYC), .LOW_CYC(LOW_CYC), .CLK_DLY(CLK_DLY), .N_CLK(N_CLK),
      .HALF(HALF), .TO_CYC(TO_CYC), .SYNC_N(2)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .cal_req_i(cal_req_i),
      .busy_i(busy_i), .data_i(data_i), .sample_o(sample_o), .cal_o(cal_o),
      .cclk_o(cclk_o), .ready_o(ready_o), .data_o(data_o), .valid_o(valid_o),
      .err_o(err_o));

   always #4 clk = ~clk;

   int tests = 0, fails = 0, wd = 0;
   int cyc = 0, s_rise = 0, s_fall = -100000, hi_len = 0, lo_len = 0, sample_rises = 0;
   int rises = 0, first_gap = -1, cc_run = 0, bad_w = 0;
   int cal_cnt = 0, after_cal = 0, cal_extra = 0, valid_cnt = 0;
   bit conv_run = 0, cal_run = 0, cal_track = 0, hang = 0;
   bit p_sample = 0, p_cclk = 0, p_cal = 0;
   logic [DATA_W-1:0] next_word = '0, cap_data = '0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: got %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
      end
   endtask

   // converter model and output monitors, all at the falling edge
   always @(negedge clk) begin
      cyc++;
      if (cal_track) after_cal++;
      if (sample_o && !p_sample) begin
         s_rise = cyc; lo_len = cyc - s_fall; sample_rises++;
      end
      if (!sample_o && p_sample) begin
         hi_len = cyc - s_rise; s_fall = cyc; busy_i <= 1'b1;
         conv_run = 1; rises = 0; first_gap = -1;
      end
      if (cclk_o) cc_run++;
      else if (p_cclk) begin
         if (conv_run && cc_run != HALF) bad_w++;
         cc_run = 0;
      end
      if (cclk_o && !p_cclk) begin
         if (conv_run) begin
            rises++;
            if (rises == 1) first_gap = cyc - s_fall;
            if (rises == N_CLK && !hang) begin
               data_i <= next_word; busy_i <= 1'b0;
            end
         end
         if (cal_run) begin
            cal_cnt++;
            if (cal_cnt == CAL_CLKS) begin
               busy_i <= 1'b0; cal_run = 0; cal_track = 1; after_cal = 0;
            end
         end else if (cal_track && after_cal >= 5) cal_extra++;
      end
      if (cal_o) begin
         busy_i <= 1'b1; cal_run = 0; cal_cnt = 0; conv_run = 0;
      end
      if (!cal_o && p_cal) begin
         cal_run = 1; cal_track = 0; cal_extra = 0;
      end
      if (valid_o) begin
         valid_cnt++; cap_data = data_o;
      end
      p_sample = sample_o; p_cclk = cclk_o; p_cal = cal_o;
   end

   always @(posedge clk) begin
      wd++;
      if (wd > 150000) begin
         fails++; tests++;
         $display("FAIL watchdog: got %0d cycles expected completion", wd);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   task automatic wait_ready();
      @(negedge clk);
      while (!ready_o) @(negedge clk);
   endtask

   task automatic do_conv(input logic [DATA_W-1:0] w);
      next_word = w;
      wait_ready();
      start_i = 1; @(negedge clk); start_i = 0;
      repeat (20) @(negedge clk);
      start_i = 1; @(negedge clk); start_i = 0;   // refused while busy
      wait_ready();
      @(posedge clk);
   endtask

   initial begin
      int k, v0, s0;
      logic [DATA_W-1:0] d0;
      repeat (3) @(negedge clk);
      // R12 reset state
      chk({sample_o, cal_o, cclk_o, ready_o, valid_o, err_o} == 6'b0, "R12", int'({sample_o, cal_o, cclk_o, ready_o, valid_o, err_o}), 0);
      chk(data_o == '0, "R12", int'(data_o), 0);
      rst_n = 1;
      k = 0;
      do begin @(negedge clk); k++; end while (!cal_o);
      chk(k == STAB_CYC, "R1 stabilisation wait", k, STAB_CYC);
      k = 0;
      do begin @(negedge clk); k++; end while (cal_o);
      chk(k == CAL_HI_CYC, "R1 calibrate pulse width", k, CAL_HI_CYC);
      repeat (5) @(negedge clk);
      chk(!ready_o, "R7 ready low in calibration", ready_o, 0);
      start_i = 1; @(negedge clk); start_i = 0;
      wait_ready();
      @(posedge clk);
      chk(cal_extra == 1, "R2 closing pulse", cal_extra, 1);
      chk(valid_cnt == 0, "R2 no strobe on calibration", valid_cnt, 0);
      chk(sample_rises == 0, "R7 start refused in calibration", sample_rises, 0);

      for (int i = 0; i < NV; i++) begin
         v0 = valid_cnt; s0 = sample_rises;
         do_conv(VEC[i][31:16]);
         chk(valid_cnt == v0 + 1, "R6 one strobe", valid_cnt - v0, 1);
         chk(cap_data == VEC[i][15:0], "R6 captured word", int'(cap_data), int'(VEC[i][15:0]));
         chk(data_o == VEC[i][15:0], "R6 word held", int'(data_o), int'(VEC[i][15:0]));
         chk(rises == N_CLK, "R5 pulse count", rises, N_CLK);
         chk(bad_w == 0, "R5 pulse width", bad_w, 0);
         chk(first_gap == CLK_DLY, "R4 clock delay", first_gap, CLK_DLY);
         chk(hi_len == ACQ_CYC, "R3 acquisition width", hi_len, ACQ_CYC);
         chk(sample_rises == s0 + 1, "R7 busy start refused", sample_rises - s0, 1);
         if (i > 0) chk(lo_len >= LOW_CYC, "R8 low gap", lo_len, LOW_CYC);
      end

      // R11 busy fall while idle
      v0 = valid_cnt; d0 = data_o;
      @(negedge clk); data_i = 16'h1234; busy_i = 1;
      repeat (5) @(negedge clk); busy_i = 0;
      repeat (8) @(negedge clk);
      chk(valid_cnt == v0, "R11 idle fall no strobe", valid_cnt - v0, 0);
      chk(data_o == d0, "R11 data unchanged", int'(data_o), int'(d0));

      // R9 timeout
      hang = 1; v0 = valid_cnt; d0 = data_o;
      do_conv(16'h5555);
      chk(err_o == 1'b1, "R9 error raised", err_o, 1);
      chk(valid_cnt == v0, "R9 no strobe", valid_cnt - v0, 0);
      chk(data_o == d0, "R9 data unchanged", int'(data_o), int'(d0));
      @(negedge clk); busy_i = 0; hang = 0;
      repeat (6) @(negedge clk);
      do_conv(16'h3C3C);
      chk(err_o == 1'b0, "R9 error cleared", err_o, 0);
      chk(data_o == 16'h3C3C, "R9 recovery capture", int'(data_o), 16'h3C3C);

      // R10 calibration request wins over start
      wait_ready();
      s0 = sample_rises; v0 = valid_cnt;
      cal_req_i = 1; start_i = 1; @(negedge clk); cal_req_i = 0; start_i = 0;
      chk(cal_o == 1'b1 && sample_o == 1'b0, "R10 calibrate wins", {cal_o, sample_o}, 2);
      wait_ready();
      @(posedge clk);
      chk(cal_extra == 1, "R10 closing pulse", cal_extra, 1);
      chk(sample_rises == s0, "R10 no acquisition", sample_rises - s0, 0);
      chk(valid_cnt == v0, "R2 no strobe", valid_cnt - v0, 0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule